// File: doc/BRIEF.md
# Packet Rename Stage with Dead-Destination Elimination

This block renames a packet of micro-ops that always dispatch together. Each slot carries two source architectural registers and an optional destination. When a destination register is written again by a later slot of the same packet, the earlier result is never seen outside the packet. That destination is therefore eliminated. It takes no physical register. Its specifier becomes a forward tag equal to its slot index, and later slots in the packet that read it receive the same forward tag. Every other destination takes the next entry offered by the free list, and the map table records the new mapping. Slots are handled in order, so a later slot sees the mappings that earlier slots made.

A packet with at least one eliminated destination leaves the block with a flag set. If such a packet faults, the core backs up to the start of the packet and presents it again with the replay input high. Elimination is then turned off and every destination is allocated, so no intermediate value is lost. When the free list cannot cover all the allocations a packet needs, the packet is held at the input and nothing changes.

A small controller has three named states:
- ST_IDLE: nothing was accepted last cycle.
- ST_EMIT: a packet was accepted last cycle and its renamed form is on the outputs.
- ST_HOLD: a packet was presented but stalled for lack of free registers.

The transitions are taken on each clock, with the same rule from every state:
- Accept leads to ST_EMIT.
- Presented-but-short leads to ST_HOLD.
- No packet leads to ST_IDLE.

Top module: `packet_rename`

## Requirements
- R1: After reset the output valid is low and the map table is the identity: architectural register a maps to physical register a, with the forward bit clear.
- R2: A destination in slot i is eliminated only when a later slot j>i in the same packet has its destination enabled and names the same architectural register. An eliminated destination is output with its forward bit set and a tag equal to i. A slot whose destination enable is low never causes an elimination.
- R3: A destination is never eliminated because of a write in a different packet, even when the next packet's first slot overwrites it.
- R4: Several destinations of one packet can be eliminated in the same cycle, including three slots that all write the register that the last slot also writes.
- R5: The packet flag is high exactly when at least one destination of the packet was eliminated.
- R6: With the replay input high, no destination is eliminated, every enabled destination is allocated, and the flag is low.
- R7: Allocation works as follows:
  - Each enabled, non-eliminated destination takes free-list offer entries in slot order: offer k goes to the k-th such slot.
  - Its forward bit is clear.
  - The pop count on an accepted packet equals the number of such destinations.
  - The map table then holds the new mapping; when two slots write the same register, the later slot's mapping wins.
- R8: A source reads the most recent earlier slot in the same packet that writes its register, if there is one. That gives the forward tag if that destination was eliminated, and the new physical register otherwise. If no earlier slot writes the register, the source reads the map table.
- R9: When the allocations a packet needs exceed the free-list count, the ready output is low and the pop count is zero. The map table is left unchanged, and no packet is emitted the next cycle.
- R10: An accepted packet appears on the outputs with valid high exactly one cycle after acceptance; in any cycle with no acceptance, valid is low the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A packet is presented |
| in_replay | input | 1 | Rename this packet with elimination off |
| in_src0 | input | NSLOT*AW | First source register per slot, slot 0 in the low bits |
| in_src1 | input | NSLOT*AW | Second source register per slot |
| in_dst | input | NSLOT*AW | Destination register per slot |
| in_dst_en | input | NSLOT | Destination enable per slot |
| in_ready | output | 1 | The free list covers the presented packet's allocations |
| fl_avail | input | CW | Free registers offered, saturated at NSLOT |
| fl_ids | input | NSLOT*PW | Offered physical registers, offer 0 in the low bits |
| fl_pop | output | CW | Number of offers consumed this cycle |
| out_valid | output | 1 | Renamed packet valid |
| out_src0_tag | output | NSLOT*PW | Renamed first source: physical register or forward tag |
| out_src0_fwd | output | NSLOT | First source comes by forwarding |
| out_src1_tag | output | NSLOT*PW | Renamed second source |
| out_src1_fwd | output | NSLOT | Second source comes by forwarding |
| out_dst_tag | output | NSLOT*PW | Renamed destination: physical register or forward tag |
| out_dst_fwd | output | NSLOT | Destination was eliminated |
| out_dst_en | output | NSLOT | Destination enable carried through |
| out_elim_flag | output | 1 | At least one destination of the packet was eliminated |

## Verification
The ready and pop results depend only on the current inputs. They are due in the same cycle as the packet and are compared one time unit after the inputs change, before the clock edge. Every renamed field and the flag are registered, so they are due one cycle after the accepting edge. The reference model computes them from the pre-edge map and compares them at the following falling edge. Valid is compared on every cycle, which confirms that stalled and idle cycles produce nothing. Map contents are observed only through later packets' source tags, in the cycle after those packets are accepted.

// File: rtl/prn_pkg.sv
`timescale 1ns/1ps
package prn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_HOLD = 2'd2
    } rn_state_e;
endpackage

// File: rtl/prn_dead_scan.sv
`timescale 1ns/1ps
// Marks destinations overwritten by a later slot of the same packet.
module prn_dead_scan #(
    parameter int NSLOT = 4,
    parameter int AW    = 4
) (
    input  logic [NSLOT-1:0][AW-1:0] dst,
    input  logic [NSLOT-1:0]         dst_en,
    input  logic                     elim_off,
    output logic [NSLOT-1:0]         kill
);
    genvar i;
    generate
        for (i = 0; i < NSLOT; i++) begin : g_slot
            logic later_hit;
            always_comb begin
                later_hit = 1'b0;
                for (int j = i + 1; j < NSLOT; j++) begin
                    if (dst_en[j] && (dst[j] == dst[i])) later_hit = 1'b1;
                end
            end
            assign kill[i] = dst_en[i] && later_hit && !elim_off;
        end
    endgenerate
endmodule

// File: rtl/prn_map_table.sv
`timescale 1ns/1ps
// Architectural-to-physical map with one ordered write port per slot.
module prn_map_table #(
    parameter int NSLOT = 4,
    parameter int AREGS = 16,
    parameter int AW    = 4,
    parameter int PW    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSLOT-1:0]         wr_en,
    input  logic [NSLOT-1:0][AW-1:0] wr_arch,
    input  logic [NSLOT-1:0][PW-1:0] wr_phys,
    output logic [AREGS-1:0][PW-1:0] rd_map
);
    logic [AREGS-1:0][PW-1:0] map_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < AREGS; a++) map_q[a] <= PW'(a);
        end else begin
            // later slots are written last and win on the same register
            for (int s = 0; s < NSLOT; s++) begin
                if (wr_en[s]) map_q[wr_arch[s]] <= wr_phys[s];
            end
        end
    end

    assign rd_map = map_q;
endmodule

// File: rtl/prn_slot_chain.sv
`timescale 1ns/1ps
// In-order renaming of sources and destinations across the packet.
module prn_slot_chain #(
    parameter int NSLOT = 4,
    parameter int AREGS = 16,
    parameter int AW    = 4,
    parameter int PW    = 5,
    parameter int CW    = 3
) (
    input  logic [AREGS-1:0][PW-1:0] map,
    input  logic [NSLOT-1:0][AW-1:0] src0,
    input  logic [NSLOT-1:0][AW-1:0] src1,
    input  logic [NSLOT-1:0][AW-1:0] dst,
    input  logic [NSLOT-1:0]         dst_en,
    input  logic [NSLOT-1:0]         kill,
    input  logic [NSLOT-1:0][PW-1:0] offer,
    output logic [NSLOT-1:0][PW-1:0] s0_tag,
    output logic [NSLOT-1:0]         s0_fwd,
    output logic [NSLOT-1:0][PW-1:0] s1_tag,
    output logic [NSLOT-1:0]         s1_fwd,
    output logic [NSLOT-1:0][PW-1:0] d_tag,
    output logic [NSLOT-1:0]         d_fwd,
    output logic [NSLOT-1:0]         alloc,
    output logic [CW-1:0]            need
);
    always_comb begin
        logic [PW-1:0] lt [NSLOT];
        logic          lf [NSLOT];
        logic [PW-1:0] t0, t1;
        logic          f0, f1;
        int            cnt;
        cnt = 0;
        for (int k = 0; k < NSLOT; k++) begin
            lt[k] = '0;
            lf[k] = 1'b0;
        end
        alloc = '0;
        for (int i = 0; i < NSLOT; i++) begin
            t0 = map[src0[i]]; f0 = 1'b0;
            t1 = map[src1[i]]; f1 = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (dst_en[j] && (dst[j] == src0[i])) begin t0 = lt[j]; f0 = lf[j]; end
                if (dst_en[j] && (dst[j] == src1[i])) begin t1 = lt[j]; f1 = lf[j]; end
            end
            s0_tag[i] = t0; s0_fwd[i] = f0;
            s1_tag[i] = t1; s1_fwd[i] = f1;
            if (dst_en[i] && kill[i]) begin
                lt[i] = PW'(i);
                lf[i] = 1'b1;
            end else if (dst_en[i]) begin
                lt[i]    = offer[cnt];
                alloc[i] = 1'b1;
                cnt      = cnt + 1;
            end
            d_tag[i] = lt[i];
            d_fwd[i] = lf[i];
        end
        need = CW'(cnt);
    end
endmodule

// File: rtl/packet_rename.sv
`timescale 1ns/1ps
module packet_rename #(
    parameter int NSLOT = 4,
    parameter int AREGS = 16,
    parameter int PREGS = 32,
    localparam int AW   = $clog2(AREGS),
    localparam int PW   = $clog2(PREGS),
    localparam int CW   = $clog2(NSLOT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_replay,
    input  logic [NSLOT*AW-1:0] in_src0,
    input  logic [NSLOT*AW-1:0] in_src1,
    input  logic [NSLOT*AW-1:0] in_dst,
    input  logic [NSLOT-1:0]    in_dst_en,
    output logic                in_ready,
    input  logic [CW-1:0]       fl_avail,
    input  logic [NSLOT*PW-1:0] fl_ids,
    output logic [CW-1:0]       fl_pop,
    output logic                out_valid,
    output logic [NSLOT*PW-1:0] out_src0_tag,
    output logic [NSLOT-1:0]    out_src0_fwd,
    output logic [NSLOT*PW-1:0] out_src1_tag,
    output logic [NSLOT-1:0]    out_src1_fwd,
    output logic [NSLOT*PW-1:0] out_dst_tag,
    output logic [NSLOT-1:0]    out_dst_fwd,
    output logic [NSLOT-1:0]    out_dst_en,
    output logic                out_elim_flag
);
    import prn_pkg::*;

    logic [NSLOT-1:0][AW-1:0] src0_a, src1_a, dst_a;
    logic [NSLOT-1:0][PW-1:0] offer_a;
    logic [AREGS-1:0][PW-1:0] map_now;
    logic [NSLOT-1:0]         kill;
    logic [NSLOT-1:0][PW-1:0] s0_tag, s1_tag, d_tag;
    logic [NSLOT-1:0]         s0_fwd, s1_fwd, d_fwd, alloc;
    logic [CW-1:0]            need;
    logic                     accept;
    rn_state_e                state_q, state_d;

    assign src0_a  = in_src0;
    assign src1_a  = in_src1;
    assign dst_a   = in_dst;
    assign offer_a = fl_ids;

    prn_dead_scan #(.NSLOT(NSLOT), .AW(AW)) u_scan (
        .dst(dst_a), .dst_en(in_dst_en), .elim_off(in_replay), .kill(kill)
    );

    prn_map_table #(.NSLOT(NSLOT), .AREGS(AREGS), .AW(AW), .PW(PW)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(alloc & {NSLOT{accept}}), .wr_arch(dst_a), .wr_phys(d_tag),
        .rd_map(map_now)
    );

    prn_slot_chain #(.NSLOT(NSLOT), .AREGS(AREGS), .AW(AW), .PW(PW), .CW(CW)) u_chain (
        .map(map_now), .src0(src0_a), .src1(src1_a), .dst(dst_a),
        .dst_en(in_dst_en), .kill(kill), .offer(offer_a),
        .s0_tag(s0_tag), .s0_fwd(s0_fwd), .s1_tag(s1_tag), .s1_fwd(s1_fwd),
        .d_tag(d_tag), .d_fwd(d_fwd), .alloc(alloc), .need(need)
    );

    assign in_ready = (need <= fl_avail);
    assign accept   = in_valid && in_ready;
    assign fl_pop   = accept ? need : '0;

    // next-state decision
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_EMIT, ST_HOLD: begin
                if (accept)        state_d = ST_EMIT;
                else if (in_valid) state_d = ST_HOLD;
                else               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        out_valid = (state_q == ST_EMIT);
    end

    // renamed packet capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_src0_tag  <= '0;
            out_src0_fwd  <= '0;
            out_src1_tag  <= '0;
            out_src1_fwd  <= '0;
            out_dst_tag   <= '0;
            out_dst_fwd   <= '0;
            out_dst_en    <= '0;
            out_elim_flag <= 1'b0;
        end else if (accept) begin
            out_src0_tag  <= s0_tag;
            out_src0_fwd  <= s0_fwd;
            out_src1_tag  <= s1_tag;
            out_src1_fwd  <= s1_fwd;
            out_dst_tag   <= d_tag;
            out_dst_fwd   <= d_fwd;
            out_dst_en    <= in_dst_en;
            out_elim_flag <= |kill;
        end
    end
endmodule

// File: rtl/prn_checker.sv
`timescale 1ns/1ps
module prn_checker #(
    parameter int NSLOT = 4,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_replay,
    input logic             in_ready,
    input logic [CW-1:0]    fl_avail,
    input logic [CW-1:0]    fl_pop,
    input logic             out_valid,
    input logic             out_elim_flag,
    input logic [NSLOT-1:0] out_dst_fwd
);
    // R10
    emit_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    // R10
    quiet_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);
    // R9
    stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |-> (fl_pop == '0));
    // R7
    pop_within_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_pop <= fl_avail);
    // R6
    replay_no_elim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_replay) |=> (!out_elim_flag && (out_dst_fwd == '0)));
    // R2
    last_slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_dst_fwd[NSLOT-1]);
endmodule

bind packet_rename prn_checker #(.NSLOT(NSLOT), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_replay(in_replay),
    .in_ready(in_ready), .fl_avail(fl_avail), .fl_pop(fl_pop),
    .out_valid(out_valid), .out_elim_flag(out_elim_flag), .out_dst_fwd(out_dst_fwd)
);

// File: tb/packet_rename_bench.sv
`timescale 1ns/1ps
module packet_rename_bench;
    localparam int NS = 4;
    localparam int AW = 4;
    localparam int PW = 5;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_replay = 1'b0;
    logic [NS*AW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
    logic [NS-1:0] in_dst_en = '0;
    logic in_ready;
    logic [CW-1:0] fl_avail = '0;
    logic [NS*PW-1:0] fl_ids = '0;
    logic [CW-1:0] fl_pop;
    logic out_valid, out_elim_flag;
    logic [NS*PW-1:0] out_src0_tag, out_src1_tag, out_dst_tag;
    logic [NS-1:0] out_src0_fwd, out_src1_fwd, out_dst_fwd, out_dst_en;

    always #2.5 clk = ~clk;

    packet_rename u_packet_rename (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_replay(in_replay),
        .in_src0(in_src0), .in_src1(in_src1), .in_dst(in_dst), .in_dst_en(in_dst_en),
        .in_ready(in_ready), .fl_avail(fl_avail), .fl_ids(fl_ids), .fl_pop(fl_pop),
        .out_valid(out_valid), .out_src0_tag(out_src0_tag), .out_src0_fwd(out_src0_fwd),
        .out_src1_tag(out_src1_tag), .out_src1_fwd(out_src1_fwd),
        .out_dst_tag(out_dst_tag), .out_dst_fwd(out_dst_fwd), .out_dst_en(out_dst_en),
        .out_elim_flag(out_elim_flag)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    string phase = "R1";

    int ref_map [16];
    int next_free = 0;
    int b_s0 [NS], b_s1 [NS], b_d [NS], b_den [NS];
    int e_s0t [NS], e_s0f [NS], e_s1t [NS], e_s1f [NS], e_dt [NS], e_df [NS], e_den [NS];
    int e_flag, e_need, e_valid;

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s [%s]: actual=%0d expected=%0d", req, what, phase, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input int s0, input int s1, input int d, input int den);
        b_s0[i] = s0; b_s1[i] = s1; b_d[i] = d; b_den[i] = den;
    endtask

    // Behavioural expectation from the requirements, using the pre-edge map.
    task automatic model(input bit rp);
        int kill [NS];
        int cnt;
        cnt = 0;
        e_flag = 0;
        for (int i = 0; i < NS; i++) begin
            kill[i] = 0;
            if (b_den[i] != 0 && !rp)
                for (int j = i + 1; j < NS; j++)
                    if (b_den[j] != 0 && b_d[j] == b_d[i]) kill[i] = 1;
            if (kill[i] != 0) e_flag = 1;
        end
        for (int i = 0; i < NS; i++) begin
            int w0, w1;
            w0 = -1; w1 = -1;
            for (int j = 0; j < i; j++) begin
                if (b_den[j] != 0 && b_d[j] == b_s0[i]) w0 = j;
                if (b_den[j] != 0 && b_d[j] == b_s1[i]) w1 = j;
            end
            e_s0t[i] = (w0 < 0) ? ref_map[b_s0[i]] : e_dt[w0];
            e_s0f[i] = (w0 < 0) ? 0 : e_df[w0];
            e_s1t[i] = (w1 < 0) ? ref_map[b_s1[i]] : e_dt[w1];
            e_s1f[i] = (w1 < 0) ? 0 : e_df[w1];
            e_den[i] = b_den[i];
            if (b_den[i] == 0) begin
                e_dt[i] = 0; e_df[i] = 0;
            end else if (kill[i] != 0) begin
                e_dt[i] = i; e_df[i] = 1;
            end else begin
                e_dt[i] = 16 + ((next_free + cnt) % 16); e_df[i] = 0;
                cnt++;
            end
        end
        e_need = cnt;
    endtask

    // Called just after a falling edge.
    task automatic step(input bit v, input bit rp, input int avail);
        bit acc;
        in_valid = v; in_replay = rp; fl_avail = CW'(avail);
        for (int i = 0; i < NS; i++) begin
            in_src0[i*AW +: AW] = AW'(b_s0[i]);
            in_src1[i*AW +: AW] = AW'(b_s1[i]);
            in_dst[i*AW +: AW]  = AW'(b_d[i]);
            in_dst_en[i]        = (b_den[i] != 0);
            fl_ids[i*PW +: PW]  = PW'(16 + ((next_free + i) % 16));
        end
        #1;
        model(rp);
        chk(int'(in_ready), (e_need <= avail) ? 1 : 0, "R9", "in_ready");
        acc = v && (e_need <= avail);
        chk(int'(fl_pop), acc ? e_need : 0, "R7", "fl_pop");
        @(posedge clk);
        if (acc) begin
            for (int i = 0; i < NS; i++)
                if (b_den[i] != 0 && e_df[i] == 0) ref_map[b_d[i]] = e_dt[i];
            next_free += e_need;
        end
        e_valid = acc ? 1 : 0;
        @(negedge clk);
        chk(int'(out_valid), e_valid, "R10", "out_valid");
        if (e_valid != 0) begin
            for (int i = 0; i < NS; i++) begin
                chk(int'(out_dst_fwd[i]), e_df[i], "R2", $sformatf("dst_fwd[%0d]", i));
                chk(int'(out_dst_tag[i*PW +: PW]), e_dt[i], "R7", $sformatf("dst_tag[%0d]", i));
                chk(int'(out_dst_en[i]), e_den[i], "R7", $sformatf("dst_en[%0d]", i));
                chk(int'(out_src0_tag[i*PW +: PW]), e_s0t[i], "R8", $sformatf("src0_tag[%0d]", i));
                chk(int'(out_src0_fwd[i]), e_s0f[i], "R8", $sformatf("src0_fwd[%0d]", i));
                chk(int'(out_src1_tag[i*PW +: PW]), e_s1t[i], "R8", $sformatf("src1_tag[%0d]", i));
                chk(int'(out_src1_fwd[i]), e_s1f[i], "R8", $sformatf("src1_fwd[%0d]", i));
            end
            chk(int'(out_elim_flag), e_flag, "R5", "elim_flag");
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog expired: actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 16; a++) ref_map[a] = a;
        for (int i = 0; i < NS; i++) set_slot(i, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(int'(out_valid), 0, "R1", "out_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(out_valid), 0, "R1", "out_valid after reset");

        // R1: identity map seen through sources
        phase = "R1";
        for (int i = 0; i < NS; i++) set_slot(i, i, i + 4, 0, 0);
        step(1, 0, 4);
        for (int i = 0; i < NS; i++) set_slot(i, i + 8, i + 12, 0, 0);
        step(1, 0, 0);

        // R7: distinct destinations, chained reads
        phase = "R7";
        set_slot(0, 0, 1, 1, 1); set_slot(1, 1, 2, 2, 1);
        set_slot(2, 2, 1, 3, 1); set_slot(3, 3, 4, 4, 1);
        step(1, 0, 4);

        // R2: slot0 overwritten by slot2, read in between
        phase = "R2";
        set_slot(0, 4, 1, 3, 1); set_slot(1, 3, 0, 5, 1);
        set_slot(2, 5, 3, 3, 1); set_slot(3, 3, 5, 6, 1);
        step(1, 0, 4);
        // disabled later write does not eliminate
        set_slot(0, 1, 2, 7, 1); set_slot(1, 7, 7, 8, 1);
        set_slot(2, 0, 0, 7, 0); set_slot(3, 7, 8, 9, 0);
        step(1, 0, 4);

        // R4: two eliminations at once
        phase = "R4";
        set_slot(0, 5, 6, 1, 1); set_slot(1, 1, 5, 2, 1);
        set_slot(2, 2, 1, 1, 1); set_slot(3, 1, 2, 2, 1);
        step(1, 0, 2);
        // three eliminations, one register
        set_slot(0, 9, 9, 9, 1); set_slot(1, 9, 0, 9, 1);
        set_slot(2, 9, 9, 9, 1); set_slot(3, 9, 1, 9, 1);
        step(1, 0, 1);

        // R6: replay of the two-elimination packet
        phase = "R6";
        set_slot(0, 5, 6, 1, 1); set_slot(1, 1, 5, 2, 1);
        set_slot(2, 2, 1, 1, 1); set_slot(3, 1, 2, 2, 1);
        step(1, 1, 4);

        // R3: overwrite lands in the next packet
        phase = "R3";
        set_slot(0, 0, 0, 7, 1); set_slot(1, 0, 0, 8, 1);
        set_slot(2, 0, 0, 10, 1); set_slot(3, 0, 0, 5, 1);
        step(1, 0, 4);
        set_slot(0, 5, 7, 5, 1); set_slot(1, 5, 8, 11, 1);
        set_slot(2, 0, 0, 12, 1); set_slot(3, 5, 0, 13, 1);
        step(1, 0, 4);

        // R9: stall, then confirm the map did not move
        phase = "R9";
        set_slot(0, 0, 0, 1, 1); set_slot(1, 0, 0, 2, 1);
        set_slot(2, 0, 0, 3, 1); set_slot(3, 0, 0, 0, 0);
        step(1, 0, 1);
        step(1, 0, 2);
        set_slot(0, 1, 2, 0, 0); set_slot(1, 3, 5, 0, 0);
        set_slot(2, 9, 7, 0, 0); set_slot(3, 0, 4, 0, 0);
        step(1, 0, 0);

        // R10: idle cycles emit nothing
        phase = "R10";
        step(0, 0, 4);
        step(0, 0, 4);
        set_slot(0, 1, 1, 14, 1); set_slot(1, 14, 0, 14, 1);
        set_slot(2, 0, 0, 0, 0); set_slot(3, 14, 14, 15, 1);
        step(1, 0, 4);
        step(0, 0, 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule